// File: doc/BRIEF.md
# Flash Command Controller

This block is the control core of a byte-wide flash memory device. It watches the active-low chip-select, output-enable, write-strobe and power-down pins, plus a flag that says the programming supply is valid. It decodes the bytes written on the data inputs as commands. Three commands choose what a read returns: the main array, the identifier bytes or the status byte. The block drives an output-enable for the 8-bit data bus, and that enable is active only when the pins call for a read.

Changing the contents always takes two writes: a setup byte, then a confirm or data byte. A program-or-erase operation then runs for a fixed number of cycles set by a parameter. The ready/busy pin stays low for that time, and reads return the status byte. Holding the power-down pin low long enough puts the device into deep power-down and aborts any running operation. Releasing the pin leaves the device in array-read mode with a clean status byte, after a wake-up interval and a longer command-recovery interval.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After the asynchronous reset, ry_by is 1, the mode is array read, every location reads FFh and a status read returns 80h.
- R2: dq_oe is 1 only while ce_n=0, oe_n=0 and we_n=1 and the device is awake; it is 0 otherwise. A write is taken on the clock edge where ce_n=0 and we_n=0, provided we_n was 1 at the previous edge.
- R3: Writing FFh selects array read, 90h selects identifier read (addr[0]=0 returns MFR_ID, default 3Ch; addr[0]=1 returns DEV_ID, default 7Ah) and 70h selects status read. Status bit 7 is ready, bit 4 is sequence error, bit 3 is supply low and bit 1 is lock refusal.
- R4: The pair 40h then a data byte programs the addressed byte to old AND data. ry_by is low for exactly PROG_CYC cycles.
- R5: The pair 20h then D0h sets every byte of the addressed block (addr[AW-1:BW]) to FFh after ERASE_CYC busy cycles.
- R6: In an erase or lock-set sequence, a second byte other than the expected confirm sets status bit 4. No operation starts and ry_by stays 1.
- R7: If vpp_ok is 0 when the second byte arrives, status bit 3 is set and the contents do not change.
- R8: The pair 60h then 01h sets the lock of the addressed block in LOCK_CYC busy cycles. A later program or erase aimed at a locked block is refused: status bit 1 is set, no busy phase runs and the data do not change.
- R9: While busy, reads return status with bit 7 at 0 and writes are ignored. Raising ce_n does not stop the operation.
- R10: rp_n held low for RP_MIN_CYC consecutive edges enters deep power-down, where dq_oe is 0. A shorter low pulse has no effect.
- R11: On leaving power-down the mode becomes array read and the status becomes 80h. dq_oe stays 0 for WAKE_CYC cycles, and writes are ignored until RECOV_CYC cycles have passed.
- R12: Entering power-down during an operation aborts it. ry_by stays low until ABORT_CYC cycles after entry, and the aborted operation leaves the contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| rp_n | input | 1 | Reset / deep power-down pin, active low |
| vpp_ok | input | 1 | Programming supply above lockout |
| addr | input | AW | Byte address |
| din | input | 8 | Command or data byte |
| dout | output | 8 | Read data |
| dq_oe | output | 1 | Data bus drive enable |
| ry_by | output | 1 | Ready (1) / busy (0) |

## Verification
The assertions assume that every pin is synchronous to clk and stable around each rising edge. They also assume that a write strobe is one low cycle framed by high cycles. The stimulus follows these rules: it changes pins 1 ns after a rising edge, it drives we_n low for exactly one cycle with ce_n low, and it never makes a read and a write at the same time. The programming-supply flag is changed only while the device is idle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } rd_mode_t;

  typedef enum logic [2:0] {
    CS_IDLE        = 3'd0,
    CS_ERASE_SETUP = 3'd1,
    CS_PROG_SETUP  = 3'd2,
    CS_LOCK_SETUP  = 3'd3,
    CS_BUSY        = 3'd4,
    CS_ABORT       = 3'd5
  } cmd_state_t;

  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_PROG  = 2'd1,
    OP_LOCK  = 2'd2
  } op_kind_t;

  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_PROG      = 8'h40;
  localparam logic [7:0] CMD_LOCK      = 8'h60;
  localparam logic [7:0] CMD_LOCK_OK   = 8'h01;

  localparam int ST_READY = 7;
  localparam int ST_SEQ   = 4;
  localparam int ST_VPP   = 3;
  localparam int ST_LOCK  = 1;

endpackage

// File: rtl/fcc_power.sv
module fcc_power #(
  parameter int RP_MIN_CYC = 13,
  parameter int WAKE_CYC   = 8,
  parameter int RECOV_CYC  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rp_n,
  output logic pd,
  output logic pd_enter,
  output logic pd_exit,
  output logic wake_done,
  output logic cmd_ok
);
  localparam int RPW      = $clog2(RP_MIN_CYC + 1);
  localparam int POST_MAX = (WAKE_CYC > RECOV_CYC) ? WAKE_CYC : RECOV_CYC;
  localparam int PW       = $clog2(POST_MAX + 1);

  logic [RPW-1:0] rp_cnt_q, rp_cnt_d;
  logic [PW-1:0]  post_q, post_d;
  logic           pd_q, pd_d;

  always_comb begin
    rp_cnt_d = rp_cnt_q;
    post_d   = post_q;
    pd_d     = pd_q;
    if (!rp_n) begin
      if (!pd_q) begin
        if (rp_cnt_q == RPW'(RP_MIN_CYC - 1)) pd_d = 1'b1;
        else                                  rp_cnt_d = rp_cnt_q + 1'b1;
      end
    end else begin
      rp_cnt_d = '0;
      if (pd_q) begin
        pd_d   = 1'b0;
        post_d = '0;
      end else if (post_q != PW'(POST_MAX)) begin
        post_d = post_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_cnt_q <= '0;
      post_q   <= PW'(POST_MAX);
      pd_q     <= 1'b0;
    end else begin
      rp_cnt_q <= rp_cnt_d;
      post_q   <= post_d;
      pd_q     <= pd_d;
    end
  end

  assign pd        = pd_q;
  assign pd_enter  = pd_d & ~pd_q;
  assign pd_exit   = pd_q & rp_n;
  assign wake_done = (post_q >= PW'(WAKE_CYC));
  assign cmd_ok    = ~pd_q & rp_n & (post_q >= PW'(RECOV_CYC));

endmodule

// File: rtl/fcc_cmd_fsm.sv
module fcc_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 6,
  parameter int BW        = 4,
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 10,
  parameter int LOCK_CYC  = 20,
  parameter int ABORT_CYC = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  vpp_ok,
  input  logic                  pd_enter,
  input  logic                  pd_exit,
  input  logic [(1<<(AW-BW))-1:0] lock_vec,
  output rd_mode_t              mode,
  output logic                  busy,
  output logic [7:0]            status,
  output logic                  commit,
  output op_kind_t              op_kind,
  output logic [AW-1:0]         op_addr,
  output logic [7:0]            op_data
);
  localparam int M1   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int M2   = (LOCK_CYC > ABORT_CYC) ? LOCK_CYC : ABORT_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXC + 1);

  cmd_state_t    state_q, state_d;
  rd_mode_t      mode_q, mode_d;
  logic [6:0]    stat_q, stat_d;
  logic [TW-1:0] timer_q, timer_d;
  op_kind_t      kind_q, kind_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    data_q, data_d;
  logic          blk_locked;

  assign blk_locked = lock_vec[wr_addr[AW-1:BW]];

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    stat_d  = stat_q;
    timer_d = timer_q;
    kind_d  = kind_q;
    addr_d  = addr_q;
    data_d  = data_q;
    commit  = 1'b0;

    if (pd_enter) begin
      if (state_q == CS_BUSY) begin
        state_d = CS_ABORT;
        timer_d = TW'(ABORT_CYC);
      end else if (state_q != CS_ABORT) begin
        state_d = CS_IDLE;
      end
    end else begin
      if (pd_exit) begin
        mode_d = RM_ARRAY;
        stat_d = '0;
      end
      case (state_q)
        CS_BUSY: begin
          if (timer_q == TW'(1)) begin
            commit  = 1'b1;
            state_d = CS_IDLE;
          end else begin
            timer_d = timer_q - 1'b1;
          end
        end
        CS_ABORT: begin
          if (timer_q == TW'(1)) state_d = CS_IDLE;
          else                   timer_d = timer_q - 1'b1;
        end
        CS_IDLE: begin
          if (wr_stb) begin
            case (wr_data)
              CMD_RD_ARRAY:  mode_d = RM_ARRAY;
              CMD_RD_IDENT:  mode_d = RM_IDENT;
              CMD_RD_STATUS: mode_d = RM_STATUS;
              CMD_ERASE: begin
                mode_d  = RM_STATUS;
                state_d = CS_ERASE_SETUP;
              end
              CMD_PROG: begin
                mode_d  = RM_STATUS;
                state_d = CS_PROG_SETUP;
              end
              CMD_LOCK: begin
                mode_d  = RM_STATUS;
                state_d = CS_LOCK_SETUP;
              end
              default: ;
            endcase
          end
        end
        CS_ERASE_SETUP, CS_PROG_SETUP, CS_LOCK_SETUP: begin
          if (wr_stb) begin
            state_d = CS_IDLE;
            addr_d  = wr_addr;
            data_d  = wr_data;
            if ((state_q == CS_ERASE_SETUP && wr_data != CMD_CONFIRM) ||
                (state_q == CS_LOCK_SETUP  && wr_data != CMD_LOCK_OK)) begin
              stat_d[ST_SEQ] = 1'b1;
            end else if (!vpp_ok) begin
              stat_d[ST_VPP] = 1'b1;
            end else if (state_q != CS_LOCK_SETUP && blk_locked) begin
              stat_d[ST_LOCK] = 1'b1;
            end else begin
              state_d = CS_BUSY;
              case (state_q)
                CS_ERASE_SETUP: begin
                  kind_d  = OP_ERASE;
                  timer_d = TW'(ERASE_CYC);
                end
                CS_PROG_SETUP: begin
                  kind_d  = OP_PROG;
                  timer_d = TW'(PROG_CYC);
                end
                default: begin
                  kind_d  = OP_LOCK;
                  timer_d = TW'(LOCK_CYC);
                end
              endcase
            end
          end
        end
        default: state_d = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      mode_q  <= RM_ARRAY;
      stat_q  <= '0;
      timer_q <= '0;
      kind_q  <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      stat_q  <= stat_d;
      timer_q <= timer_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign busy    = (state_q == CS_BUSY) || (state_q == CS_ABORT);
  assign status  = {~busy, stat_q};
  assign mode    = mode_q;
  assign op_kind = kind_q;
  assign op_addr = addr_q;
  assign op_data = data_q;

endmodule

// File: rtl/fcc_store.sv
module fcc_store
  import flash_cmd_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  op_kind_t                op_kind,
  input  logic [AW-1:0]           op_addr,
  input  logic [7:0]              op_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [7:0]              rd_data,
  output logic [(1<<(AW-BW))-1:0] lock_vec
);
  localparam int DEPTH = 1 << AW;
  localparam int NBLK  = 1 << (AW - BW);
  localparam int NBW   = AW - BW;

  logic [7:0] words [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam int BLK = w >> BW;
    logic [7:0] q, d;
    logic       en;
    always_comb begin
      en = 1'b0;
      d  = q;
      if (commit) begin
        if (op_kind == OP_ERASE && op_addr[AW-1:BW] == NBW'(BLK)) begin
          en = 1'b1;
          d  = 8'hFF;
        end else if (op_kind == OP_PROG && op_addr == AW'(w)) begin
          en = 1'b1;
          d  = q & op_data;
        end
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 8'hFF;
      else if (en) q <= d;
    end
    assign words[w] = q;
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_lock
    logic q, en;
    assign en = commit && (op_kind == OP_LOCK) && (op_addr[AW-1:BW] == NBW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= 1'b1;
    end
    assign lock_vec[b] = q;
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int         AW         = 6,
  parameter int         BW         = 4,
  parameter int         ERASE_CYC  = 40,
  parameter int         PROG_CYC   = 10,
  parameter int         LOCK_CYC   = 20,
  parameter int         ABORT_CYC  = 6,
  parameter int         RP_MIN_CYC = 13,
  parameter int         WAKE_CYC   = 8,
  parameter int         RECOV_CYC  = 16,
  parameter logic [7:0] MFR_ID     = 8'h3C,
  parameter logic [7:0] DEV_ID     = 8'h7A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          rp_n,
  input  logic          vpp_ok,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dq_oe,
  output logic          ry_by
);
  localparam int NBLK = 1 << (AW - BW);

  logic            we_q;
  logic            wr_stb;
  logic            pd, pd_enter, pd_exit, wake_done, cmd_ok;
  rd_mode_t        mode;
  logic            busy, commit;
  logic [7:0]      status, rd_data;
  op_kind_t        op_kind;
  logic [AW-1:0]   op_addr;
  logic [7:0]      op_data;
  logic [NBLK-1:0] lock_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign wr_stb = ~ce_n & ~we_n & we_q & cmd_ok;

  fcc_power #(
    .RP_MIN_CYC(RP_MIN_CYC), .WAKE_CYC(WAKE_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_power (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .pd(pd), .pd_enter(pd_enter),
    .pd_exit(pd_exit), .wake_done(wake_done), .cmd_ok(cmd_ok)
  );

  fcc_cmd_fsm #(
    .AW(AW), .BW(BW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
    .LOCK_CYC(LOCK_CYC), .ABORT_CYC(ABORT_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(addr), .wr_data(din),
    .vpp_ok(vpp_ok), .pd_enter(pd_enter), .pd_exit(pd_exit), .lock_vec(lock_vec),
    .mode(mode), .busy(busy), .status(status), .commit(commit),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
  );

  fcc_store #(.AW(AW), .BW(BW)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .rd_addr(addr), .rd_data(rd_data),
    .lock_vec(lock_vec)
  );

  always_comb begin
    if (busy) begin
      dout = status;
    end else begin
      case (mode)
        RM_ARRAY: dout = rd_data;
        RM_IDENT: dout = addr[0] ? DEV_ID : MFR_ID;
        default:  dout = status;
      endcase
    end
  end

  assign dq_oe = ~ce_n & ~oe_n & we_n & ~pd & wake_done;
  assign ry_by = ~busy;

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
  import flash_cmd_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     ce_n,
  input logic     oe_n,
  input logic     we_n,
  input logic     rp_n,
  input logic     dq_oe,
  input logic     dout_msb,
  input logic     ry_by,
  input logic     pd,
  input logic     wake_done,
  input rd_mode_t mode
);

  a_r2_bus_needs_pins: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!ce_n && !oe_n && we_n));

  a_r10_quiet_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> !dq_oe);

  a_r10_entry_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd) |-> $past(!rp_n));

  a_r9_busy_reads_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!ry_by && dq_oe) |-> !dout_msb);

  a_r11_array_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd) |-> (mode == RM_ARRAY));

  a_r11_hidden_while_waking: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_done |-> !dq_oe);

  a_r12_abort_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd) && $past(!ry_by)) |-> !ry_by);

endmodule

bind flash_cmd_ctrl fcc_checker u_fcc_checker (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
  .dq_oe(dq_oe), .dout_msb(dout[7]), .ry_by(ry_by), .pd(pd),
  .wake_done(wake_done), .mode(mode)
);

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
  localparam int AW = 6;

  logic          clk, rst_n, ce_n, oe_n, we_n, rp_n, vpp_ok;
  logic [AW-1:0] addr;
  logic [7:0]    din, dout;
  logic          dq_oe, ry_by;
  logic          rd_strobe;
  int            n_chk, n_fail, n;
  bit            done;

  typedef struct {
    logic [7:0] d;
    logic       oe;
    string      tag;
  } exp_t;
  exp_t sb[$];

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rp_n(rp_n), .vpp_ok(vpp_ok), .addr(addr), .din(din), .dout(dout),
    .dq_oe(dq_oe), .ry_by(ry_by)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads and compares
  always @(negedge clk) begin
    if (rd_strobe && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (!e.oe) chk(dq_oe == 1'b0, {e.tag, " oe"}, dq_oe, 0);
      else begin
        chk(dq_oe == 1'b1, {e.tag, " oe"}, dq_oe, 1);
        chk(dout == e.d, e.tag, dout, e.d);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(posedge clk); #1;
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] d, input logic oe,
                    input string tag);
    exp_t e;
    @(posedge clk); #1;
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    e.d = d; e.oe = oe; e.tag = tag;
    sb.push_back(e);
    rd_strobe = 1'b1;
    @(posedge clk); #1;
    rd_strobe = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_ready(output int cnt);
    cnt = 0;
    while (!ry_by && cnt < 2000) begin
      @(posedge clk); #1;
      cnt++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; rp_n = 1'b1;
    vpp_ok = 1'b1; addr = '0; din = 8'hFF; rd_strobe = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk(ry_by == 1'b1, "R1 ready after reset", ry_by, 1);
    chk(dq_oe == 1'b0, "R1 bus idle", dq_oe, 0);
    rd(6'h05, 8'hFF, 1'b1, "R1 erased array");
    wr(6'h00, 8'h70);
    rd(6'h00, 8'h80, 1'b1, "R1 status 80h");
    wr(6'h00, 8'hFF);

    // R2 pin gating
    ce_n = 1'b1; oe_n = 1'b0; #1;
    chk(dq_oe == 1'b0, "R2 ce high", dq_oe, 0);
    ce_n = 1'b0; oe_n = 1'b1; #1;
    chk(dq_oe == 1'b0, "R2 oe high", dq_oe, 0);
    oe_n = 1'b0; we_n = 1'b0; din = 8'hFF; #1;
    chk(dq_oe == 1'b0, "R2 we low", dq_oe, 0);
    we_n = 1'b1; #1;
    chk(dq_oe == 1'b1, "R2 all active", dq_oe, 1);
    ce_n = 1'b1; oe_n = 1'b1;

    // R3 read modes
    wr(6'h00, 8'h90);
    rd(6'h00, 8'h3C, 1'b1, "R3 maker id");
    rd(6'h01, 8'h7A, 1'b1, "R3 device id");
    wr(6'h00, 8'hFF);
    rd(6'h01, 8'hFF, 1'b1, "R3 back to array");

    // R4 byte write
    wr(6'h03, 8'h40);
    wr(6'h03, 8'h5A);
    wait_ready(n);
    chk(n == 10, "R4 R9 program busy length", n, 10);
    wr(6'h00, 8'hFF);
    rd(6'h03, 8'h5A, 1'b1, "R4 programmed");
    wr(6'h03, 8'h40);
    wr(6'h03, 8'h0F);
    wait_ready(n);
    wr(6'h00, 8'hFF);
    rd(6'h03, 8'h0A, 1'b1, "R4 AND semantics");

    // R5 erase, R9 busy behaviour and deselect
    wr(6'h05, 8'h20);
    wr(6'h05, 8'hD0);
    rd(6'h03, 8'h00, 1'b1, "R9 status while busy");
    wr(6'h00, 8'hFF);
    rd(6'h03, 8'h00, 1'b1, "R9 write ignored while busy");
    wait_ready(n);
    chk(n == 34, "R9 runs on while deselected", n, 34);
    rd(6'h03, 8'h80, 1'b1, "R5 status after erase");
    wr(6'h00, 8'hFF);
    rd(6'h03, 8'hFF, 1'b1, "R5 block erased");

    // R6 sequence error
    wr(6'h00, 8'h20);
    wr(6'h00, 8'h33);
    chk(ry_by == 1'b1, "R6 no busy", ry_by, 1);
    rd(6'h00, 8'h90, 1'b1, "R6 sequence error bit");
    wr(6'h00, 8'hFF);

    // R7 supply low
    vpp_ok = 1'b0;
    wr(6'h07, 8'h40);
    wr(6'h07, 8'h00);
    chk(ry_by == 1'b1, "R7 no busy", ry_by, 1);
    rd(6'h07, 8'h98, 1'b1, "R7 supply low bit");
    vpp_ok = 1'b1;
    wr(6'h00, 8'hFF);
    rd(6'h07, 8'hFF, 1'b1, "R7 contents kept");

    // R8 lock set and refusal
    wr(6'h10, 8'h60);
    wr(6'h10, 8'h01);
    wait_ready(n);
    chk(n == 20, "R8 lock busy length", n, 20);
    wr(6'h12, 8'h40);
    wr(6'h12, 8'h00);
    chk(ry_by == 1'b1, "R8 refused no busy", ry_by, 1);
    rd(6'h12, 8'h9A, 1'b1, "R8 lock refusal bit");
    wr(6'h00, 8'hFF);
    rd(6'h12, 8'hFF, 1'b1, "R8 locked data kept");

    // R10 short pulse ignored
    wr(6'h00, 8'h90);
    @(posedge clk); #1 rp_n = 1'b0;
    repeat (12) @(posedge clk);
    #1 rp_n = 1'b1;
    rd(6'h00, 8'h3C, 1'b1, "R10 short pulse ignored");

    // R10 R11 power-down and exit
    @(posedge clk); #1 rp_n = 1'b0;
    repeat (15) @(posedge clk);
    #1;
    rd(6'h00, 8'h00, 1'b0, "R10 outputs off in power-down");
    repeat (3) @(posedge clk);
    #1 rp_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk); #1;
    chk(dq_oe == 1'b0, "R11 hidden during wake", dq_oe, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(posedge clk);
    wr(6'h00, 8'h70);
    repeat (20) @(posedge clk);
    rd(6'h12, 8'hFF, 1'b1, "R11 array mode and early write ignored");
    wr(6'h00, 8'h70);
    rd(6'h00, 8'h80, 1'b1, "R11 status cleared");

    // R12 abort
    wr(6'h24, 8'h40);
    wr(6'h24, 8'h11);
    wait_ready(n);
    wr(6'h24, 8'h20);
    wr(6'h24, 8'hD0);
    @(posedge clk); @(posedge clk); #1;
    rp_n = 1'b0;
    wait_ready(n);
    chk(n == 19, "R12 busy until abort done", n, 19);
    @(posedge clk); #1 rp_n = 1'b1;
    repeat (20) @(posedge clk);
    rd(6'h24, 8'h11, 1'b1, "R12 aborted erase left data");

    repeat (4) @(posedge clk);
    chk(sb.size() == 0, "R1 scoreboard drained", sb.size(), 0);
    finish_run();
  end

endmodule